// File: doc/BRIEF.md
# Glitch-Free Clock Power-Down Controller

This block sits between a set of free-running source clocks and the chip's clock outputs. When an asynchronous, active-high power-down request arrives, it stops every output cleanly and then asks the upstream oscillator to shut down. When the request is removed, it restarts every output without runt or truncated pulses. Single-ended outputs stop at a low level. Differential outputs stop with the true leg held high. For each differential pair, a drive-mode bit chooses whether the complement leg alone, or both legs, are released to a floating state. Floating is modelled by a separate output-enable for each leg, not by high-impedance values.

The request is filtered first. It counts only once it has been sampled high on two rising edges in a row of the qualifying clock. The accepted request then passes through a synchroniser into each output clock domain. Each domain gates its clock at the edge that matches its parked level, and reports back once it has parked. The oscillator-off request rises only when every domain has reported parked, and it drops as soon as the accepted request drops.

Top module: `clkpd_ctrl`

## Requirements
- R1: After reset, every output clock follows its source clock, every leg output-enable is 1, and `osc_off_o` is 0.
- R2: A power-down request takes effect only if `pd_i` is high at two consecutive rising edges of `qual_clk_i`. A pulse that covers zero or one such edge stops no output and does not raise `osc_off_o`.
- R3: Once the request is accepted, each single-ended output stops low at a falling edge of its source. No high pulse is ever shortened.
- R4: Once the request is accepted, each differential pair stops at a falling edge of its complement leg, with the true leg high and the complement leg low. No pulse on either leg is shortened.
- R5: While a pair is parked and its drive-mode bit is 0, its true-leg enable is 1 and its complement-leg enable is 0.
- R6: While a pair is parked and its drive-mode bit is 1, both leg enables are 0.
- R7: `osc_off_o` rises only after every output has parked. It falls while the outputs are still parked, before any output restarts.
- R8: After the request is released, every output toggles again with full-width pulses, and all leg enables return to 1.
- R9: The complement leg of each pair is always the logical inverse of its true leg.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| qual_clk_i | input | 1 | Clock that samples the power-down request |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_i | input | 1 | Asynchronous active-high power-down request |
| se_clk_i | input | N_SE | Single-ended source clocks |
| dp_clk_i | input | N_DIFF | Differential source clocks (true phase) |
| dp_mode_i | input | N_DIFF | Parked drive mode per pair: 0 keeps true leg driven, 1 floats both |
| se_clk_o | output | N_SE | Gated single-ended clocks |
| dp_t_o | output | N_DIFF | Gated true legs |
| dp_c_o | output | N_DIFF | Gated complement legs |
| dp_t_oe_o | output | N_DIFF | True-leg output enable (0 means floating) |
| dp_c_oe_o | output | N_DIFF | Complement-leg output enable (0 means floating) |
| osc_off_o | output | 1 | Request to stop the upstream oscillator |

## Verification
The hardest case to reach is a request whose arrival phase falls at an awkward point against several clocks with unrelated periods. In that case a careless gate cuts a pulse short at the moment of stopping or restarting. The stimulus sweeps the request's arrival offset across the whole qualifying period, for every drive-mode combination. Edge monitors time every output pulse against its source half-period. Short pulses that straddle zero or one qualifying edge check the two-edge filter.

// File: rtl/clkpd_pkg.sv
`timescale 1ns/1ps
package clkpd_pkg;

   // fewest flops allowed in any crossing chain
   localparam int unsigned MIN_SYNC_STAGES = 2;
   // fewest consecutive qualifying samples allowed
   localparam int unsigned MIN_QUAL_EDGES = 2;

   typedef enum logic {
      PARK_TRUE_HIGH  = 1'b0,
      PARK_FLOAT_BOTH = 1'b1
   } park_mode_e;

endpackage

// File: rtl/clkpd_sync.sv
`timescale 1ns/1ps
module clkpd_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < clkpd_pkg::MIN_SYNC_STAGES) begin : g_bad_stages
      $error("clkpd_sync: STAGES below minimum");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/clkpd_qualify.sv
`timescale 1ns/1ps
module clkpd_qualify #(
   parameter int unsigned QUAL_EDGES  = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned N_DOMAINS   = 2
) (
   input  logic                 qual_clk_i,
   input  logic                 rst_ni,
   input  logic                 pd_i,
   input  logic [N_DOMAINS-1:0] parked_i,
   output logic                 accept_o,
   output logic                 osc_off_o
);

   if (QUAL_EDGES < clkpd_pkg::MIN_QUAL_EDGES) begin : g_bad_edges
      $error("clkpd_qualify: QUAL_EDGES below minimum");
   end

   logic [QUAL_EDGES-1:0] smp_q;
   logic                  all_parked_sync;

   // history of the raw request, one bit per qualifying edge
   always_ff @(posedge qual_clk_i or negedge rst_ni) begin
      if (!rst_ni) smp_q <= '0;
      else         smp_q <= {smp_q[QUAL_EDGES-2:0], pd_i};
   end

   assign accept_o = &smp_q;

   clkpd_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
   ) u_park_sync (
      .clk_i  (qual_clk_i),
      .rst_ni (rst_ni),
      .d_i    (&parked_i),
      .q_o    (all_parked_sync)
   );

   assign osc_off_o = accept_o & all_parked_sync;

endmodule

// File: rtl/clkpd_se_gate.sv
`timescale 1ns/1ps
module clkpd_se_gate #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic src_clk_i,
   input  logic rst_ni,
   input  logic stop_req_i,
   output logic clk_o,
   output logic parked_o
);

   logic req_sync;
   logic run_q;

   clkpd_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
   ) u_req_sync (
      .clk_i  (src_clk_i),
      .rst_ni (rst_ni),
      .d_i    (stop_req_i),
      .q_o    (req_sync)
   );

   // enable changes only while the source is low
   always_ff @(negedge src_clk_i or negedge rst_ni) begin
      if (!rst_ni) run_q <= 1'b1;
      else         run_q <= !req_sync;
   end

   assign clk_o    = src_clk_i & run_q;
   assign parked_o = !run_q & req_sync;

endmodule

// File: rtl/clkpd_diff_gate.sv
`timescale 1ns/1ps
module clkpd_diff_gate #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic src_clk_i,
   input  logic rst_ni,
   input  logic stop_req_i,
   input  logic park_mode_i,
   output logic t_o,
   output logic c_o,
   output logic t_oe_o,
   output logic c_oe_o,
   output logic parked_o
);

   import clkpd_pkg::*;

   logic       req_sync;
   logic       halt_q;
   park_mode_e mode_sel;

   clkpd_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
   ) u_req_sync (
      .clk_i  (src_clk_i),
      .rst_ni (rst_ni),
      .d_i    (stop_req_i),
      .q_o    (req_sync)
   );

   // halt changes only while the true phase is high (complement just fell)
   always_ff @(posedge src_clk_i or negedge rst_ni) begin
      if (!rst_ni) halt_q <= 1'b0;
      else         halt_q <= req_sync;
   end

   assign mode_sel = park_mode_e'(park_mode_i);
   assign t_o      = src_clk_i | halt_q;
   assign c_o      = ~src_clk_i & ~halt_q;
   assign c_oe_o   = !halt_q;
   assign t_oe_o   = !(halt_q && (mode_sel == PARK_FLOAT_BOTH));
   assign parked_o = halt_q & req_sync;

endmodule

// File: rtl/clkpd_ctrl.sv
`timescale 1ns/1ps
module clkpd_ctrl #(
   parameter int unsigned N_SE        = 3,
   parameter int unsigned N_DIFF      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned QUAL_EDGES  = 2
) (
   input  logic              qual_clk_i,
   input  logic              rst_ni,
   input  logic              pd_i,
   input  logic [N_SE-1:0]   se_clk_i,
   input  logic [N_DIFF-1:0] dp_clk_i,
   input  logic [N_DIFF-1:0] dp_mode_i,
   output logic [N_SE-1:0]   se_clk_o,
   output logic [N_DIFF-1:0] dp_t_o,
   output logic [N_DIFF-1:0] dp_c_o,
   output logic [N_DIFF-1:0] dp_t_oe_o,
   output logic [N_DIFF-1:0] dp_c_oe_o,
   output logic              osc_off_o
);

   localparam int unsigned N_DOMAINS = N_SE + N_DIFF;

   if (N_SE < 1) begin : g_bad_se
      $error("clkpd_ctrl: N_SE must be at least 1");
   end
   if (N_DIFF < 1) begin : g_bad_diff
      $error("clkpd_ctrl: N_DIFF must be at least 1");
   end
   if (SYNC_STAGES < clkpd_pkg::MIN_SYNC_STAGES) begin : g_bad_sync
      $error("clkpd_ctrl: SYNC_STAGES below minimum");
   end

   logic                 accept;
   logic [N_DOMAINS-1:0] parked;

   clkpd_qualify #(
      .QUAL_EDGES  (QUAL_EDGES),
      .SYNC_STAGES (SYNC_STAGES),
      .N_DOMAINS   (N_DOMAINS)
   ) u_qualify (
      .qual_clk_i (qual_clk_i),
      .rst_ni     (rst_ni),
      .pd_i       (pd_i),
      .parked_i   (parked),
      .accept_o   (accept),
      .osc_off_o  (osc_off_o)
   );

   for (genvar s = 0; s < N_SE; s++) begin : g_se
      clkpd_se_gate #(
         .SYNC_STAGES (SYNC_STAGES)
      ) u_gate (
         .src_clk_i  (se_clk_i[s]),
         .rst_ni     (rst_ni),
         .stop_req_i (accept),
         .clk_o      (se_clk_o[s]),
         .parked_o   (parked[s])
      );
   end

   for (genvar d = 0; d < N_DIFF; d++) begin : g_diff
      clkpd_diff_gate #(
         .SYNC_STAGES (SYNC_STAGES)
      ) u_gate (
         .src_clk_i   (dp_clk_i[d]),
         .rst_ni      (rst_ni),
         .stop_req_i  (accept),
         .park_mode_i (dp_mode_i[d]),
         .t_o         (dp_t_o[d]),
         .c_o         (dp_c_o[d]),
         .t_oe_o      (dp_t_oe_o[d]),
         .c_oe_o      (dp_c_oe_o[d]),
         .parked_o    (parked[N_SE+d])
      );
   end

endmodule

// File: rtl/clkpd_ctrl_chk.sv
`timescale 1ns/1ps
module clkpd_ctrl_chk #(
   parameter int unsigned N_SE   = 3,
   parameter int unsigned N_DIFF = 2
) (
   input logic                     qual_clk_i,
   input logic                     rst_ni,
   input logic                     pd_i,
   input logic [N_SE-1:0]          se_clk_i,
   input logic [N_DIFF-1:0]        dp_clk_i,
   input logic [N_DIFF-1:0]        dp_mode_i,
   input logic [N_SE-1:0]          se_clk_o,
   input logic [N_DIFF-1:0]        dp_t_o,
   input logic [N_DIFF-1:0]        dp_c_o,
   input logic [N_DIFF-1:0]        dp_t_oe_o,
   input logic [N_DIFF-1:0]        dp_c_oe_o,
   input logic                     osc_off_o,
   input logic [N_SE+N_DIFF-1:0]   parked_i
);

   // R2
   two_edge_chk: assert property (@(posedge qual_clk_i) disable iff (!rst_ni)
      osc_off_o |-> ($past(pd_i) && $past(pd_i, 2)));

   // R7
   off_after_park_chk: assert property (@(posedge qual_clk_i) disable iff (!rst_ni)
      osc_off_o |-> ((&parked_i) && (se_clk_o == '0) && (dp_c_oe_o == '0)));

   for (genvar s = 0; s < N_SE; s++) begin : g_se_chk
      // R3
      se_low_chk: assert property (@(negedge se_clk_i[s]) disable iff (!rst_ni)
         parked_i[s] |-> !se_clk_o[s]);
   end

   for (genvar d = 0; d < N_DIFF; d++) begin : g_dp_chk
      // R4
      dp_park_level_chk: assert property (@(posedge dp_clk_i[d]) disable iff (!rst_ni)
         parked_i[N_SE+d] |-> (dp_t_o[d] && !dp_c_o[d]));
      // R5
      dp_mode0_oe_chk: assert property (@(negedge dp_clk_i[d]) disable iff (!rst_ni)
         (!dp_c_oe_o[d] && !dp_mode_i[d]) |-> dp_t_oe_o[d]);
      // R6
      dp_mode1_oe_chk: assert property (@(negedge dp_clk_i[d]) disable iff (!rst_ni)
         (!dp_c_oe_o[d] && dp_mode_i[d]) |-> !dp_t_oe_o[d]);
      // R9
      dp_comp_chk: assert property (@(posedge qual_clk_i) disable iff (!rst_ni)
         dp_c_o[d] == !dp_t_o[d]);
   end

endmodule

bind clkpd_ctrl clkpd_ctrl_chk #(
   .N_SE   (N_SE),
   .N_DIFF (N_DIFF)
) u_chk (
   .qual_clk_i (qual_clk_i),
   .rst_ni     (rst_ni),
   .pd_i       (pd_i),
   .se_clk_i   (se_clk_i),
   .dp_clk_i   (dp_clk_i),
   .dp_mode_i  (dp_mode_i),
   .se_clk_o   (se_clk_o),
   .dp_t_o     (dp_t_o),
   .dp_c_o     (dp_c_o),
   .dp_t_oe_o  (dp_t_oe_o),
   .dp_c_oe_o  (dp_c_oe_o),
   .osc_off_o  (osc_off_o),
   .parked_i   (parked)
);

// File: tb/clkpd_ctrl_bench.sv
`timescale 1ns/1ps
module clkpd_ctrl_bench;

   localparam int N_SE   = 3;
   localparam int N_DIFF = 2;

   function automatic real se_half(input int i);
      case (i)
         0:       return 5.0;
         1:       return 7.0;
         default: return 15.0;
      endcase
   endfunction

   function automatic real dp_half(input int i);
      if (i == 0) return 6.0;
      return 8.0;
   endfunction

   logic              qual_clk = 1'b0;
   logic              rst_n    = 1'b0;
   logic              pd       = 1'b0;
   logic [N_SE-1:0]   se_clk   = '0;
   logic [N_DIFF-1:0] dp_clk   = '0;
   logic [N_DIFF-1:0] mode     = '0;
   logic [N_SE-1:0]   se_out;
   logic [N_DIFF-1:0] t_out, c_out, t_oe, c_oe;
   logic              osc_off;

   int tests = 0;
   int fails = 0;
   bit mon_on = 1'b0;
   int off_rises = 0;
   int coe_falls = 0;
   int se_rises [N_SE];
   int dp_rises [N_DIFF];
   bit done = 1'b0;

   clkpd_ctrl #(.N_SE(N_SE), .N_DIFF(N_DIFF)) u_clkpd_ctrl (
      .qual_clk_i (qual_clk),
      .rst_ni     (rst_n),
      .pd_i       (pd),
      .se_clk_i   (se_clk),
      .dp_clk_i   (dp_clk),
      .dp_mode_i  (mode),
      .se_clk_o   (se_out),
      .dp_t_o     (t_out),
      .dp_c_o     (c_out),
      .dp_t_oe_o  (t_oe),
      .dp_c_oe_o  (c_oe),
      .osc_off_o  (osc_off)
   );

   // 50 MHz qualifying clock, unrelated output clocks
   initial forever #10 qual_clk = ~qual_clk;
   initial begin #1.3; forever #5  se_clk[0] = ~se_clk[0]; end
   initial begin #2.1; forever #7  se_clk[1] = ~se_clk[1]; end
   initial begin #3.7; forever #15 se_clk[2] = ~se_clk[2]; end
   initial begin #0.9; forever #6  dp_clk[0] = ~dp_clk[0]; end
   initial begin #4.4; forever #8  dp_clk[1] = ~dp_clk[1]; end

   task automatic chk(input bit ok, input string msg);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s", msg);
      end
   endtask

   // pulse-width monitors: R3/R8 single-ended, R4/R8 true leg
   for (genvar g = 0; g < N_SE; g++) begin : g_semon
      realtime last = 0;
      always @(se_out[g]) begin
         if (mon_on && last > 0) begin
            if (se_out[g] == 1'b0)
               chk((($realtime - last) > se_half(g) - 0.01) && (($realtime - last) < se_half(g) + 0.01),
                   $sformatf("R3/R8 se%0d high pulse actual %0.3f expected %0.3f", g, $realtime - last, se_half(g)));
            else
               chk(($realtime - last) > se_half(g) - 0.01,
                   $sformatf("R3/R8 se%0d low pulse actual %0.3f expected >= %0.3f", g, $realtime - last, se_half(g)));
         end
         if (se_out[g]) se_rises[g]++;
         last = $realtime;
      end
   end

   for (genvar g = 0; g < N_DIFF; g++) begin : g_dpmon
      realtime last = 0;
      always @(t_out[g]) begin
         if (mon_on && last > 0) begin
            if (t_out[g] == 1'b1)
               chk((($realtime - last) > dp_half(g) - 0.01) && (($realtime - last) < dp_half(g) + 0.01),
                   $sformatf("R4/R8 dp%0d true low pulse actual %0.3f expected %0.3f", g, $realtime - last, dp_half(g)));
            else
               chk(($realtime - last) > dp_half(g) - 0.01,
                   $sformatf("R4/R8 dp%0d true high pulse actual %0.3f expected >= %0.3f", g, $realtime - last, dp_half(g)));
         end
         if (t_out[g]) dp_rises[g]++;
         last = $realtime;
      end
   end

   // R7: ordering of the oscillator-off request against parking
   always @(posedge osc_off) begin
      off_rises++;
      #0.1;
      chk((se_out == '0) && (c_oe == '0) && (t_out == '1),
          $sformatf("R7 at off rise se=%b c_oe=%b t=%b expected se=000 c_oe=00 t=11", se_out, c_oe, t_out));
   end
   always @(negedge osc_off) begin
      if (rst_n) begin
         #0.1;
         chk((se_out == '0) && (c_oe == '0),
             $sformatf("R7 at off fall se=%b c_oe=%b expected still parked", se_out, c_oe));
      end
   end
   always @(negedge c_oe[0]) if (rst_n) coe_falls++;

   task automatic check_comp(input string when);
      for (int k = 0; k < 4; k++) begin
         #2.3;
         chk(c_out == ~t_out, $sformatf("R9 %s c=%b t=%b expected c=~t", when, c_out, t_out));
      end
   endtask

   task automatic check_parked(input logic [N_DIFF-1:0] m, input int tag);
      chk(osc_off == 1'b1, $sformatf("R7 case %0d osc_off actual %b expected 1", tag, osc_off));
      for (int k = 0; k < 6; k++) begin
         #3.1;
         chk(se_out == '0, $sformatf("R3 case %0d se actual %b expected 000", tag, se_out));
         chk((t_out == '1) && (c_out == '0),
             $sformatf("R4 case %0d t=%b c=%b expected t=11 c=00", tag, t_out, c_out));
      end
      for (int d = 0; d < N_DIFF; d++) begin
         if (m[d] == 1'b0)
            chk((t_oe[d] == 1'b1) && (c_oe[d] == 1'b0),
                $sformatf("R5 case %0d pair%0d t_oe=%b c_oe=%b expected 1 0", tag, d, t_oe[d], c_oe[d]));
         else
            chk((t_oe[d] == 1'b0) && (c_oe[d] == 1'b0),
                $sformatf("R6 case %0d pair%0d t_oe=%b c_oe=%b expected 0 0", tag, d, t_oe[d], c_oe[d]));
      end
      check_comp("parked");
   endtask

   task automatic check_running(input string req, input int tag);
      int s0 [N_SE];
      int d0 [N_DIFF];
      chk(osc_off == 1'b0, $sformatf("%s case %0d osc_off actual %b expected 0", req, tag, osc_off));
      chk((t_oe == '1) && (c_oe == '1),
          $sformatf("%s case %0d t_oe=%b c_oe=%b expected all ones", req, tag, t_oe, c_oe));
      for (int i = 0; i < N_SE; i++) s0[i] = se_rises[i];
      for (int i = 0; i < N_DIFF; i++) d0[i] = dp_rises[i];
      #100;
      for (int i = 0; i < N_SE; i++)
         chk(se_rises[i] - s0[i] >= 2,
             $sformatf("%s case %0d se%0d rises actual %0d expected >= 2", req, tag, i, se_rises[i] - s0[i]));
      for (int i = 0; i < N_DIFF; i++)
         chk(dp_rises[i] - d0[i] >= 2,
             $sformatf("%s case %0d dp%0d rises actual %0d expected >= 2", req, tag, i, dp_rises[i] - d0[i]));
      check_comp("running");
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      int accepted;
      #55 rst_n = 1'b1;
      // R1: reset state
      for (int k = 0; k < 5; k++) begin
         #3.3;
         chk((se_out == se_clk) && (t_out == dp_clk),
             $sformatf("R1 outputs se=%b t=%b expected se=%b t=%b", se_out, t_out, se_clk, dp_clk));
      end
      chk((osc_off == 1'b0) && (t_oe == '1) && (c_oe == '1),
          $sformatf("R1 osc_off=%b t_oe=%b c_oe=%b expected 0 11 11", osc_off, t_oe, c_oe));
      mon_on = 1'b1;

      // R2: pulse between edges, then pulse over one edge
      @(posedge qual_clk); #2 pd = 1'b1; #10 pd = 1'b0;
      @(posedge qual_clk); #2 pd = 1'b1; @(posedge qual_clk); #2 pd = 1'b0;
      repeat (30) @(posedge qual_clk);
      #3;
      chk(off_rises == 0, $sformatf("R2 osc_off rises actual %0d expected 0", off_rises));
      chk(coe_falls == 0, $sformatf("R2 pair parks actual %0d expected 0", coe_falls));
      check_running("R2", 0);

      // accepted requests: every mode combination, several arrival phases
      accepted = 0;
      for (int m = 0; m < 4; m++) begin
         for (int off = 0; off < 5; off++) begin
            mode = m[1:0];
            @(posedge qual_clk);
            #(1.0 + 4.0 * off) pd = 1'b1;
            accepted++;
            repeat (25) @(posedge qual_clk);
            #3;
            check_parked(mode, m * 5 + off);
            pd = 1'b0;
            repeat (25) @(posedge qual_clk);
            #3;
            check_running("R8", m * 5 + off);
         end
      end
      chk(off_rises == accepted, $sformatf("R7 osc_off rises actual %0d expected %0d", off_rises, accepted));
      done = 1'b1;
      finish_run();
   end

   initial begin
      #500000;
      if (!done) begin
         chk(1'b0, "watchdog run not finished actual timeout expected completion");
         finish_run();
      end
   end

endmodule